// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog configured by one 8-bit register. The register carries a two-bit resolution code in bits 1:0, a five-bit multiplier in bits 6:2 and a steering bit in bit 7. The countdown advances on a 16 Hz tick that arrives as a one-cycle pulse on the system clock. The timeout, counted in ticks of 1/16 s, is the multiplier times four raised to the resolution code. A multiplier of zero leaves the watchdog idle.

Software services the watchdog in either of two ways. It can write the register, which restarts the count with the new value. It can strobe a read, which restarts the count with the stored value. Either action clears the watchdog flag. On expiry the flag is set and the counter stops. The steering bit then chooses the action. When it is set, the block pulses a system reset request, clears its own register and pulses a clear for the century bit of a neighbouring day register. When it is clear, the block pulses the interrupt line for one cycle.

Top module: `wdog_steer`

## Requirements
- R1: The timeout is multiplier (bits 6:2) × 4^resolution (bits 1:0) ticks. Expiry happens on that tick after the restart. A tick that arrives in the same cycle as a restart is not counted.
- R2: A write loads the register in the next cycle and restarts the countdown. If the multiplier of the written value is zero, the watchdog stays idle and never expires.
- R3: A read strobe restarts the countdown using the stored value and leaves the register unchanged. rd_data_o always shows the register.
- R4: Every restart, by write or by read, clears flag_o in the following cycle.
- R5: Expiry sets flag_o in the cycle after the expiring tick. The flag then holds until the next restart.
- R6: With bit 7 set at expiry, rst_req_o and cent_clr_o pulse high together for exactly one cycle, and the register reads zero from that cycle on.
- R7: With bit 7 clear at expiry, irq_o pulses high for exactly one cycle and the register keeps its value. irq_o and rst_req_o are never high together.
- R8: After expiry the countdown stays stopped. No further pulse appears until a restart.
- R9: After reset, flag_o, irq_o, rst_req_o, cent_clr_o and rd_data_o are all zero and the watchdog is idle.
- R10: A write and a read strobe in the same cycle act as the write. A restart in the same cycle as an expiring tick prevents the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 16 Hz tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write value |
| rd_en_i | input | 1 | Register read strobe (restarts count) |
| rd_data_o | output | 8 | Current register value |
| flag_o | output | 1 | Watchdog expired flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| rst_req_o | output | 1 | One-cycle system reset request |
| cent_clr_o | output | 1 | One-cycle clear for neighbour century bit |

## Verification
The bench targets the exact expiry tick for several resolutions, up to the full 1984-tick span. An off-by-one counter would fire a tick early or late. It also targets a restart landing on the expiring tick. A design that checks expiry before restart would pulse there, and the following interval would be one tick short. It checks that a zero multiplier with a non-zero resolution stays idle, because a design that tests the whole byte for zero would fire at once. It also checks that steered expiry clears the register, since a design that keeps the register would re-arm on the next read strobe.

// File: rtl/wdog_steer_pkg.sv
package wdog_steer_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_RST  = 2'd2
  } wd_act_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int unsigned MULT_W = 5,
  parameter int unsigned RES_W  = 2,
  localparam int unsigned REG_W = MULT_W + RES_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              clr_i,
  output logic [REG_W-1:0]  reg_o,
  output logic [REG_W-1:0]  restart_val_o
);
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reg_q <= '0;
    else if (wr_en_i) reg_q <= wr_data_i;
    else if (clr_i)   reg_q <= '0;
  end

  // a write restarts with the fresh value, a read with the stored one
  assign restart_val_o = wr_en_i ? wr_data_i : reg_q;
  assign reg_o         = reg_q;
endmodule

// File: rtl/wdog_span.sv
module wdog_span #(
  parameter int unsigned MULT_W = 5,
  parameter int unsigned RES_W  = 2,
  localparam int unsigned NRES  = 1 << RES_W,
  localparam int unsigned CNT_W = MULT_W + 2 * (NRES - 1)
) (
  input  logic [MULT_W-1:0] mult_i,
  input  logic [RES_W-1:0]  res_i,
  output logic [CNT_W-1:0]  span_o
);
  logic [CNT_W-1:0] cand [NRES];

  for (genvar g = 0; g < NRES; g++) begin : g_res
    assign cand[g] = {{(CNT_W-MULT_W){1'b0}}, mult_i} << (2 * g);
  end

  assign span_o = cand[res_i];
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  // restart takes precedence over the expiring tick
  assign expire_o = busy_q & tick_i & ~load_i & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      busy_q <= |load_val_i;
    end else if (expire_o) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_act.sv
module wdog_act
  import wdog_steer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic expire_i,
  input  logic steer_i,
  output logic flag_o,
  output logic irq_o,
  output logic rst_req_o,
  output logic cent_clr_o
);
  wd_act_e act_d, act_q;
  logic    flag_q;

  always_comb begin
    act_d = ACT_NONE;
    if (expire_i) act_d = steer_i ? ACT_RST : ACT_IRQ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= ACT_NONE;
      flag_q <= 1'b0;
    end else begin
      act_q <= act_d;
      if (restart_i)     flag_q <= 1'b0;
      else if (expire_i) flag_q <= 1'b1;
    end
  end

  assign flag_o     = flag_q;
  assign irq_o      = (act_q == ACT_IRQ);
  assign rst_req_o  = (act_q == ACT_RST);
  assign cent_clr_o = (act_q == ACT_RST);
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int unsigned MULT_W = 5,
  parameter int unsigned RES_W  = 2,
  localparam int unsigned REG_W = MULT_W + RES_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             cent_clr_o
);
  localparam int unsigned NRES  = 1 << RES_W;
  localparam int unsigned CNT_W = MULT_W + 2 * (NRES - 1);
  localparam int unsigned STEER = REG_W - 1;

  logic [REG_W-1:0] reg_val, restart_val;
  logic [CNT_W-1:0] span;
  logic             restart, expire, steer_clr;

  assign restart   = wr_en_i | rd_en_i;
  assign steer_clr = expire & reg_val[STEER];

  wdog_cfg_reg #(.MULT_W(MULT_W), .RES_W(RES_W)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .clr_i         (steer_clr),
    .reg_o         (reg_val),
    .restart_val_o (restart_val)
  );

  wdog_span #(.MULT_W(MULT_W), .RES_W(RES_W)) u_span (
    .mult_i (restart_val[RES_W +: MULT_W]),
    .res_i  (restart_val[RES_W-1:0]),
    .span_o (span)
  );

  wdog_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (restart),
    .load_val_i (span),
    .tick_i     (tick_i),
    .expire_o   (expire)
  );

  wdog_act u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .expire_i   (expire),
    .steer_i    (reg_val[STEER]),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .cent_clr_o (cent_clr_o)
  );

  assign rd_data_o = reg_val;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             rd_en_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             cent_clr_o
);
  // R2
  write_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  // R3
  read_keeps_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> rd_data_o == $past(rd_data_o));

  // R4
  restart_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i || rd_en_i) |=> !flag_o);

  // R5
  flag_rise_has_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> (irq_o ^ rst_req_o));

  // R6
  rst_req_clears_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rd_data_o == '0 && cent_clr_o));

  // R6
  rst_req_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R7
  irq_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R7
  irq_rst_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));

  // R8
  stopped_after_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !wr_en_i && !rd_en_i) |=> (flag_o && !irq_o && !rst_req_o));
endmodule

bind wdog_steer wdog_steer_chk #(.REG_W(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .rst_req_o  (rst_req_o),
  .cent_clr_o (cent_clr_o)
);

// File: tb/tb_wdog_steer.sv
`timescale 1ns/1ps
module tb_wdog_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       flag, irq, rreq, cclr;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  wdog_steer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr), .wr_data_i(wdata),
    .rd_en_i(rd), .rd_data_o(rdata), .flag_o(flag), .irq_o(irq),
    .rst_req_o(rreq), .cent_clr_o(cclr)
  );

  // behavioural reference
  int   m_reg, m_rem;
  bit   m_act, m_flag, m_irq, m_rst;

  function automatic int span_of(int v);
    return ((v >> 2) & 31) * (1 << (2 * (v & 3)));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0; m_rem = 0; m_act = 0; m_flag = 0; m_irq = 0; m_rst = 0;
    end else begin
      m_irq = 0; m_rst = 0;
      if (wr || rd) begin
        if (wr) m_reg = wdata;
        m_rem  = span_of(m_reg);
        m_act  = (m_rem != 0);
        m_flag = 0;
      end else if (m_act && tick) begin
        m_rem--;
        if (m_rem == 0) begin
          m_act  = 0;
          m_flag = 1;
          if (m_reg[7]) begin m_rst = 1; m_reg = 0; end
          else m_irq = 1;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R5 flag vs model", flag, m_flag);
    check("R7 irq vs model", irq, m_irq);
    check("R6 rst_req vs model", rreq, m_rst);
    check("R6 cent_clr vs model", cclr, m_rst);
    check("R3 rd_data vs model", rdata, m_reg);
  end

  task automatic step(bit t, bit w, int d, bit r);
    @(negedge clk);
    tick = t; wr = w; wdata = 8'(d); rd = r;
    @(posedge clk);
    #1;
    tick = 0; wr = 0; rd = 0;
  endtask

  // ticks, returning how many pulses of each kind were seen
  task automatic ticks(int n, output int n_irq, output int n_rst);
    n_irq = 0; n_rst = 0;
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 0);
      n_irq += irq; n_rst += rreq;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ni, nr;
    repeat (3) @(negedge clk);
    check("R9 flag", flag, 0); check("R9 irq", irq, 0);
    check("R9 rst_req", rreq, 0); check("R9 cent_clr", cclr, 0);
    check("R9 rd_data", rdata, 0);
    rst_n = 1;
    ticks(5, ni, nr);
    check("R9 idle after reset", ni + nr, 0);

    // 0x05: mult 1, res 1 -> 4 ticks, interrupt
    step(0, 1, 8'h05, 0);
    check("R2 write loads", rdata, 8'h05);
    ticks(3, ni, nr);
    check("R1 no early expiry", ni + nr + flag, 0);
    step(1, 0, 0, 0);
    check("R1 expiry on 4th tick", irq, 1);
    check("R5 flag set", flag, 1);
    check("R7 register kept", rdata, 8'h05);
    step(0, 0, 0, 0);
    check("R7 irq single cycle", irq, 0);
    ticks(10, ni, nr);
    check("R8 stopped after expiry", ni + nr, 0);
    check("R5 flag holds", flag, 1);

    step(0, 0, 0, 1);
    check("R4 read clears flag", flag, 0);
    check("R3 read keeps reg", rdata, 8'h05);
    ticks(3, ni, nr);
    check("R3 read restarts, not early", ni, 0);
    step(1, 0, 0, 0);
    check("R3 read restart expires", irq, 1);

    // 0x88: steer, mult 2, res 0 -> 2 ticks, reset request
    step(0, 1, 8'h88, 0);
    check("R4 write clears flag", flag, 0);
    step(1, 0, 0, 0);
    check("R6 not early", rreq, 0);
    step(1, 0, 0, 0);
    check("R6 rst_req", rreq, 1);
    check("R6 cent_clr", cclr, 1);
    check("R6 no irq", irq, 0);
    check("R6 reg cleared", rdata, 0);
    step(0, 0, 0, 0);
    check("R6 rst_req single cycle", rreq, 0);
    step(0, 0, 0, 1);
    ticks(20, ni, nr);
    check("R2 cleared reg stays idle", ni + nr + flag, 0);
    step(0, 1, 8'h01, 0);
    ticks(20, ni, nr);
    check("R2 zero multiplier idle", ni + nr + flag, 0);

    // 0x0A: mult 2, res 2 -> 32 ticks
    step(0, 1, 8'h0A, 0);
    ticks(31, ni, nr);
    check("R1 res2 not early", ni, 0);
    step(1, 0, 0, 0);
    check("R1 res2 expiry", irq, 1);

    // mid-count read restart, 0x0C -> 3 ticks
    step(0, 1, 8'h0C, 0);
    ticks(2, ni, nr);
    step(0, 0, 0, 1);
    ticks(2, ni, nr);
    check("R3 mid restart not early", ni, 0);
    step(1, 0, 0, 0);
    check("R3 mid restart expiry", irq, 1);

    // restart on expiring tick
    step(0, 1, 8'h04, 0);
    step(1, 0, 0, 1);
    check("R10 read on expiring tick blocks", irq + flag, 0);
    step(1, 0, 0, 0);
    check("R10 expires after restart", irq, 1);
    step(0, 1, 8'h04, 0);
    step(1, 1, 8'h08, 0);
    check("R10 write on expiring tick", irq + flag, 0);
    check("R10 new value", rdata, 8'h08);
    ticks(2, ni, nr);
    check("R10 new span used", ni, 1);
    step(0, 1, 8'h0C, 1);
    check("R10 write wins over read", rdata, 8'h0C);

    // full span 0x7F -> 1984 ticks
    step(0, 1, 8'h7F, 0);
    ticks(1983, ni, nr);
    check("R1 full span not early", ni + flag, 0);
    step(1, 0, 0, 0);
    check("R1 full span expiry", irq, 1);

    // random traffic, checked against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      int d;
      d = {$urandom_range(0, 1), 2'b00, 3'($urandom_range(0, 3)), 2'($urandom_range(0, 1))};
      step($urandom_range(0, 2) != 0, $urandom_range(0, 40) == 0, d,
           $urandom_range(0, 60) == 0);
    end

    step(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule